// File: doc/BRIEF.md
# Chainable Performance Event Counter Bank

This block holds a set of event counters and one free-running cycle counter for performance monitoring. Each event counter has an event-type register. Depending on that type, the counter advances on a pulse of an external event line, on a software-increment write, or, for an odd-numbered counter, on the overflow of the even counter just below it. Joining two counters this way extends a count beyond one counter's width. Every counter that wraps flags its own overflow-status bit. A level interrupt is raised while any flagged overflow also has its interrupt-enable bit set.

Software reaches the bank through simple register-style strobes. There is a control write that carries global run, two clear actions and a long-counter mode. Enable, overflow-status and interrupt-enable each have a set strobe and a clear strobe that share one 32-bit mask bus. A software-increment strobe uses the same mask. Counter and event-type writes select their target with an index, and a combinational read port returns the value and event type at a read index. Event inputs arrive as a pulse vector with one line per event number.

Bit position 31 of every mask and index 31 of every counter address belong to the cycle counter. Positions 0 to NUM_EVT-1 belong to the event counters. All other positions are unimplemented.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, all counters, event types, enable, overflow-status and interrupt-enable bits, global run and long mode are zero, and `irq` is low.
- R2: A running event counter whose type k is neither 0x000 nor 0x01E (with k < EVT_CODES) increments by one at each clock edge where `evt_in[k]` is high. A counter is running when global run (control bit 0) and its enable bit are both 1. Types of EVT_CODES or above never count.
- R3: With global run at 0, no counter changes except through writes and clears, and the cycle counter holds.
- R4: The cycle counter (index 31) increments every cycle while running, is 64 bits wide, wraps from all ones to zero and then sets overflow bit 31.
- R5: With long mode off, an event counter is 32 bits wide. It wraps from 0xFFFF_FFFF to 0 and sets its own overflow bit. A counter write keeps only the low 32 bits, and bits 63:32 read 0.
- R6: With long mode on (control bit 3), event counters are 64 bits wide and flag overflow only when wrapping from all ones in 64 bits. Crossing 0xFFFF_FFFF then gives 0x1_0000_0000 and no overflow.
- R7: An odd counter with type 0x01E, when running, increments in the same cycle that the even counter below it wraps. The even counter still sets its own overflow bit. If the odd counter is not enabled, the chain event is lost.
- R8: A software-increment strobe increments each running counter of type 0x000 whose mask bit is 1. Such an increment can overflow and chain.
- R9: Control bit 1 clears all event counters at that edge and leaves the cycle counter alone. Control bit 2 clears the cycle counter. Both clears win over writes and increments.
- R10: For the enable, overflow-status and interrupt-enable registers, 1s on the set strobe set bits and 1s on the clear strobe clear bits. Set wins when both strobes come together. A hardware overflow wins over a clear. Unimplemented positions read 0.
- R11: `irq` is high exactly while some position has both its overflow-status and interrupt-enable bits at 1.
- R12: A counter write loads `cnt_wdata` into the counter at `wr_idx` at the next edge, winning over an increment in that cycle. An event-type write loads the 10-bit type of an event counter. The cycle counter's type reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | EVT_CODES | Event pulse lines, one per event number |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 4 | Bit 0 run, bit 1 clear event counters, bit 2 clear cycle counter, bit 3 long mode |
| mask_wdata | input | 32 | Shared mask for set/clear and software-increment strobes |
| en_set_we | input | 1 | Set enable bits |
| en_clr_we | input | 1 | Clear enable bits |
| ovf_set_we | input | 1 | Set overflow-status bits |
| ovf_clr_we | input | 1 | Clear overflow-status bits |
| ie_set_we | input | 1 | Set interrupt-enable bits |
| ie_clr_we | input | 1 | Clear interrupt-enable bits |
| swinc_we | input | 1 | Software-increment strobe |
| cnt_we | input | 1 | Counter write strobe |
| evtype_we | input | 1 | Event-type write strobe |
| wr_idx | input | 5 | Counter index for writes |
| cnt_wdata | input | 64 | Counter write data |
| evtype_wdata | input | 10 | Event-type write data |
| rd_idx | input | 5 | Counter index for reads |
| rd_cnt | output | 64 | Value of counter at rd_idx |
| rd_evtype | output | 10 | Event type of counter at rd_idx |
| ctrl_q | output | 2 | {long mode, global run} |
| en_q | output | 32 | Enable bits |
| ovf_q | output | 32 | Overflow-status bits |
| ie_q | output | 32 | Interrupt-enable bits |
| irq | output | 1 | Level overflow interrupt |

## Verification
A lost or doubled chain event shows up as an odd counter that is one off at the read port right after the edge where the even counter wraps, so it can be seen within one cycle of the wrap. A wrong width mode shows as bits 63:32 that are nonzero in legacy mode, or as a missing or early overflow bit when crossing 0xFFFF_FFFF. Both appear at the first wrap after the mode changes. Errors in the mask registers show at once on `en_q`, `ovf_q`, `ie_q` and `irq`. A counter that is enabled when it should not be drifts away from the expected value by one count per event pulse.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
// Shared constants for the performance counter bank: counter address space,
// reserved event codes and control-word bit positions.
package pcb_pkg;
    localparam int MAX_CNT  = 32;                // address space of counters
    localparam int CYC_IDX  = MAX_CNT - 1;       // cycle counter slot
    localparam int IDX_W    = $clog2(MAX_CNT);
    localparam int CNT_W    = 64;
    localparam int TYPE_W   = 10;
    localparam logic [TYPE_W-1:0] EV_SWINC = 10'h000;
    localparam logic [TYPE_W-1:0] EV_CHAIN = 10'h01E;
    localparam int CTRL_W   = 4;
    localparam int CTL_RUN  = 0;
    localparam int CTL_ECLR = 1;
    localparam int CTL_CCLR = 2;
    localparam int CTL_LONG = 3;
endpackage

// File: rtl/pcb_mask_reg.sv
`timescale 1ns/1ps
// Set/clear mask register. Set strobe wins over clear strobe; hardware set
// input wins over clear. Positions outside VALID always read zero.
module pcb_mask_reg #(
    parameter int W = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wmask,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    logic [W-1:0] set_v, clr_v;

    // decode the strobes into set and clear vectors
    always_comb begin
        set_v = set_we ? wmask : '0;
        clr_v = clr_we ? wmask : '0;
    end

    // update the register
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= ((q & ~clr_v) | set_v | hw_set) & VALID;
    end
endmodule

// File: rtl/pcb_evt_slice.sv
`timescale 1ns/1ps
// One event counter with its event-type register. Picks the count source
// from the type, advances by one, and reports a wrap at 32 or 64 bits.
// Assumes at most one increment source per cycle (types are exclusive).
module pcb_evt_slice
    import pcb_pkg::*;
#(
    parameter int EVT_CODES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 long_mode,
    input  logic                 run,
    input  logic [EVT_CODES-1:0] evt_in,
    input  logic                 swinc_hit,
    input  logic                 chain_in,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [CNT_W-1:0]     wr_data,
    input  logic                 type_we,
    input  logic [TYPE_W-1:0]    type_wdata,
    output logic [CNT_W-1:0]     cnt_q,
    output logic [TYPE_W-1:0]    type_q,
    output logic                 ovf_pulse
);
    localparam int SEL_W = (EVT_CODES > 1) ? $clog2(EVT_CODES) : 1;

    logic             ext_hit, hit, wrap;
    logic [CNT_W-1:0] nxt;

    // choose the increment source selected by the event type
    always_comb begin
        ext_hit = (32'(type_q) < 32'(EVT_CODES)) && evt_in[type_q[SEL_W-1:0]];
        if (type_q == EV_SWINC)      hit = run && swinc_hit;
        else if (type_q == EV_CHAIN) hit = run && chain_in;
        else                         hit = run && ext_hit;
    end

    // next value and wrap detection for the active width
    always_comb begin
        if (long_mode) begin
            wrap = &cnt_q;
            nxt  = cnt_q + 64'd1;
        end else begin
            wrap = &cnt_q[31:0];
            nxt  = {32'h0, cnt_q[31:0] + 32'h1};
        end
        ovf_pulse = hit && wrap;
    end

    // counter register: clear, then write, then increment
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (wr_en) cnt_q <= long_mode ? wr_data : {32'h0, wr_data[31:0]};
        else if (hit)   cnt_q <= nxt;
    end

    // event-type register
    always_ff @(posedge clk) begin
        if (!rst_n)       type_q <= '0;
        else if (type_we) type_q <= type_wdata;
    end
endmodule

// File: rtl/pcb_cyc_counter.sv
`timescale 1ns/1ps
// Always-64-bit cycle counter. Counts every cycle while running and reports
// a wrap from all ones.
module pcb_cyc_counter
    import pcb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_pulse
);
    // wrap flag for this cycle's increment
    always_comb ovf_pulse = run && (&cnt_q);

    // counter register: clear, then write, then count
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (wr_en) cnt_q <= wr_data;
        else if (run)   cnt_q <= cnt_q + 64'd1;
    end
endmodule

// File: rtl/perf_counter_bank.sv
`timescale 1ns/1ps
// Performance counter bank: NUM_EVT event counters (NUM_EVT <= 31) plus a
// cycle counter at index 31. Odd counters may chain on the even counter
// below. Register-style strobes drive control, masks and counter writes.
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int NUM_EVT   = 4,
    parameter int EVT_CODES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EVT_CODES-1:0] evt_in,
    input  logic                 ctrl_we,
    input  logic [CTRL_W-1:0]    ctrl_wdata,
    input  logic [MAX_CNT-1:0]   mask_wdata,
    input  logic                 en_set_we,
    input  logic                 en_clr_we,
    input  logic                 ovf_set_we,
    input  logic                 ovf_clr_we,
    input  logic                 ie_set_we,
    input  logic                 ie_clr_we,
    input  logic                 swinc_we,
    input  logic                 cnt_we,
    input  logic                 evtype_we,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [CNT_W-1:0]     cnt_wdata,
    input  logic [TYPE_W-1:0]    evtype_wdata,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [CNT_W-1:0]     rd_cnt,
    output logic [TYPE_W-1:0]    rd_evtype,
    output logic [1:0]           ctrl_q,
    output logic [MAX_CNT-1:0]   en_q,
    output logic [MAX_CNT-1:0]   ovf_q,
    output logic [MAX_CNT-1:0]   ie_q,
    output logic                 irq
);
    localparam logic [MAX_CNT-1:0] VALID_MASK =
        (32'h1 << CYC_IDX) | ((32'h1 << NUM_EVT) - 32'h1);

    logic                 gen_en, long_mode;
    logic [MAX_CNT-1:0]   run_vec, hw_ovf;
    logic                 ev_clr, cyc_clr, cyc_ovf;
    logic [NUM_EVT-1:0]   evt_ovf;
    logic [CNT_W-1:0]     evt_cnt  [NUM_EVT];
    logic [TYPE_W-1:0]    evt_type [NUM_EVT];
    logic [CNT_W-1:0]     cyc_cnt;

    // global control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en    <= 1'b0;
            long_mode <= 1'b0;
        end else if (ctrl_we) begin
            gen_en    <= ctrl_wdata[CTL_RUN];
            long_mode <= ctrl_wdata[CTL_LONG];
        end
    end

    // per-counter run qualifiers and one-shot clear actions
    always_comb begin
        run_vec = gen_en ? en_q : '0;
        ev_clr  = ctrl_we && ctrl_wdata[CTL_ECLR];
        cyc_clr = ctrl_we && ctrl_wdata[CTL_CCLR];
    end

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_cnt
        logic chain_in, ovf;
        if (g % 2 == 1) begin : g_odd
            assign chain_in = g_cnt[g-1].ovf;
        end else begin : g_even
            assign chain_in = 1'b0;
        end
        pcb_evt_slice #(.EVT_CODES(EVT_CODES)) slice_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .long_mode  (long_mode),
            .run        (run_vec[g]),
            .evt_in     (evt_in),
            .swinc_hit  (swinc_we && mask_wdata[g]),
            .chain_in   (chain_in),
            .clr        (ev_clr),
            .wr_en      (cnt_we && (wr_idx == IDX_W'(g))),
            .wr_data    (cnt_wdata),
            .type_we    (evtype_we && (wr_idx == IDX_W'(g))),
            .type_wdata (evtype_wdata),
            .cnt_q      (evt_cnt[g]),
            .type_q     (evt_type[g]),
            .ovf_pulse  (ovf)
        );
        assign evt_ovf[g] = ovf;
    end

    pcb_cyc_counter cyc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_vec[CYC_IDX]),
        .clr       (cyc_clr),
        .wr_en     (cnt_we && (wr_idx == IDX_W'(CYC_IDX))),
        .wr_data   (cnt_wdata),
        .cnt_q     (cyc_cnt),
        .ovf_pulse (cyc_ovf)
    );

    // gather the wrap pulses into overflow-status positions
    always_comb hw_ovf = MAX_CNT'(evt_ovf) | (MAX_CNT'(cyc_ovf) << CYC_IDX);

    pcb_mask_reg #(.W(MAX_CNT), .VALID(VALID_MASK)) en_reg_i (
        .clk(clk), .rst_n(rst_n), .set_we(en_set_we), .clr_we(en_clr_we),
        .wmask(mask_wdata), .hw_set('0), .q(en_q));

    pcb_mask_reg #(.W(MAX_CNT), .VALID(VALID_MASK)) ovf_reg_i (
        .clk(clk), .rst_n(rst_n), .set_we(ovf_set_we), .clr_we(ovf_clr_we),
        .wmask(mask_wdata), .hw_set(hw_ovf), .q(ovf_q));

    pcb_mask_reg #(.W(MAX_CNT), .VALID(VALID_MASK)) ie_reg_i (
        .clk(clk), .rst_n(rst_n), .set_we(ie_set_we), .clr_we(ie_clr_we),
        .wmask(mask_wdata), .hw_set('0), .q(ie_q));

    // level interrupt and control readback
    always_comb begin
        irq    = |(ovf_q & ie_q);
        ctrl_q = {long_mode, gen_en};
    end

    // combinational read port
    always_comb begin
        rd_cnt    = '0;
        rd_evtype = '0;
        if (rd_idx == IDX_W'(CYC_IDX)) rd_cnt = cyc_cnt;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_cnt    = evt_cnt[i];
                rd_evtype = evt_type[i];
            end
        end
    end
endmodule

// File: rtl/pcb_checker.sv
`timescale 1ns/1ps
// Property checker for the performance counter bank, attached by bind.
// Observes ports plus the internal run bit and cycle counter value.
module pcb_checker #(
    parameter int NUM_EVT = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_we,
    input logic [3:0]  ctrl_wdata,
    input logic        cnt_we,
    input logic [4:0]  wr_idx,
    input logic        en_set_we,
    input logic        en_clr_we,
    input logic        ovf_set_we,
    input logic [31:0] mask_wdata,
    input logic [31:0] en_q,
    input logic [31:0] ovf_q,
    input logic [31:0] ie_q,
    input logic        irq,
    input logic [4:0]  rd_idx,
    input logic [63:0] rd_cnt,
    input logic        gen_en,
    input logic [63:0] cyc_cnt
);
    localparam logic [31:0] VALID = (32'h1 << 31) | ((32'h1 << NUM_EVT) - 32'h1);

    logic cyc_busy;
    always_comb cyc_busy = (ctrl_we && ctrl_wdata[2]) || (cnt_we && wr_idx == 5'd31);

    // R9
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_we && ctrl_wdata[1]) && (32'(rd_idx) < NUM_EVT)) |-> (rd_cnt == 64'd0));

    // R9
    cyc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata[2]) |=> (cyc_cnt == 64'd0));

    // R3
    cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(gen_en && en_q[31]) && !cyc_busy) |=> $stable(cyc_cnt));

    // R4
    cyc_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && en_q[31] && !cyc_busy) |=> (cyc_cnt == $past(cyc_cnt) + 64'd1));

    // R10
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set_we |=> ((ovf_q & $past(mask_wdata)) == ($past(mask_wdata) & VALID)));

    // R10
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr_we && !en_set_we) |=> ((en_q & $past(mask_wdata)) == 32'h0));

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q == 32'h0) |-> !irq);
endmodule

bind perf_counter_bank pcb_checker #(.NUM_EVT(NUM_EVT)) chk_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cnt_we(cnt_we), .wr_idx(wr_idx), .en_set_we(en_set_we),
    .en_clr_we(en_clr_we), .ovf_set_we(ovf_set_we), .mask_wdata(mask_wdata),
    .en_q(en_q), .ovf_q(ovf_q), .ie_q(ie_q), .irq(irq), .rd_idx(rd_idx),
    .rd_cnt(rd_cnt), .gen_en(gen_en), .cyc_cnt(cyc_cnt));

// File: tb/perf_counter_bank_tb.sv
`timescale 1ns/1ps
module perf_counter_bank_tb_top;
    localparam int N  = 4;
    localparam int EC = 32;
    localparam logic [31:0] VALID = (32'h1 << 31) | ((32'h1 << N) - 32'h1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [EC-1:0] evt_in;
    logic ctrl_we, en_set_we, en_clr_we, ovf_set_we, ovf_clr_we, ie_set_we, ie_clr_we;
    logic swinc_we, cnt_we, evtype_we;
    logic [3:0]  ctrl_wdata;
    logic [31:0] mask_wdata;
    logic [4:0]  wr_idx, rd_idx;
    logic [63:0] cnt_wdata, rd_cnt;
    logic [9:0]  evtype_wdata, rd_evtype;
    logic [1:0]  ctrl_q;
    logic [31:0] en_q, ovf_q, ie_q;
    logic irq;

    always #10 clk = ~clk;

    perf_counter_bank #(.NUM_EVT(N), .EVT_CODES(EC)) dut_i (.*);

    // expected state
    logic [63:0] m_cnt [32];
    logic [9:0]  m_type [32];
    logic [31:0] m_en, m_ovf, m_ie;
    logic m_gen, m_long;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic clear_inputs();
        evt_in = '0; ctrl_we = 0; ctrl_wdata = '0; mask_wdata = '0;
        en_set_we = 0; en_clr_we = 0; ovf_set_we = 0; ovf_clr_we = 0;
        ie_set_we = 0; ie_clr_we = 0; swinc_we = 0; cnt_we = 0; evtype_we = 0;
        wr_idx = '0; cnt_wdata = '0; evtype_wdata = '0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) begin m_cnt[i] = '0; m_type[i] = '0; end
        m_en = '0; m_ovf = '0; m_ie = '0; m_gen = 0; m_long = 0;
    endtask

    // next expected state from the requirements, using the inputs now driven
    task automatic model_step();
        logic [63:0] nc [32];
        logic [31:0] ovp, run, setv, clrv;
        ovp = '0;
        run = m_gen ? m_en : '0;
        for (int i = 0; i < 32; i++) nc[i] = m_cnt[i];
        for (int i = 0; i < N; i++) begin
            bit hit, wrap;
            if (m_type[i] == 10'h000)      hit = run[i] && swinc_we && mask_wdata[i];
            else if (m_type[i] == 10'h01E) hit = run[i] && (i % 2 == 1) && ovp[(i + 31) % 32];
            else                           hit = run[i] && (m_type[i] < EC) && evt_in[m_type[i][4:0]];
            wrap = m_long ? (&m_cnt[i]) : (&m_cnt[i][31:0]);
            if (hit) begin
                nc[i] = m_long ? m_cnt[i] + 64'd1 : {32'h0, m_cnt[i][31:0] + 32'h1};
                if (wrap) ovp[i] = 1'b1;
            end
        end
        if (run[31]) begin
            if (&m_cnt[31]) ovp[31] = 1'b1;
            nc[31] = m_cnt[31] + 64'd1;
        end
        if (cnt_we) begin
            if (wr_idx == 5'd31) nc[31] = cnt_wdata;
            else if (wr_idx < N) nc[wr_idx] = m_long ? cnt_wdata : {32'h0, cnt_wdata[31:0]};
        end
        if (ctrl_we && ctrl_wdata[1]) for (int i = 0; i < N; i++) nc[i] = '0;
        if (ctrl_we && ctrl_wdata[2]) nc[31] = '0;
        if (evtype_we && wr_idx < N) m_type[wr_idx] = evtype_wdata;
        setv = en_set_we ? mask_wdata : '0;  clrv = en_clr_we ? mask_wdata : '0;
        m_en = ((m_en & ~clrv) | setv) & VALID;
        setv = ovf_set_we ? mask_wdata : '0; clrv = ovf_clr_we ? mask_wdata : '0;
        m_ovf = ((m_ovf & ~clrv) | setv | ovp) & VALID;
        setv = ie_set_we ? mask_wdata : '0;  clrv = ie_clr_we ? mask_wdata : '0;
        m_ie = ((m_ie & ~clrv) | setv) & VALID;
        if (ctrl_we) begin m_gen = ctrl_wdata[0]; m_long = ctrl_wdata[3]; end
        for (int i = 0; i < 32; i++) m_cnt[i] = nc[i];
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input int idx, output logic [63:0] v);
        rd_idx = 5'(idx); #1; v = rd_cnt;
    endtask

    task automatic check_state(string tag);
        for (int k = 0; k <= N; k++) begin
            int idx;
            idx = (k == N) ? 31 : k;
            rd_idx = 5'(idx); #1;
            chk({tag, " count"}, rd_cnt, m_cnt[idx]);
            chk({tag, " type"}, 64'(rd_evtype), 64'(m_type[idx]));
        end
        chk({tag, " en"}, 64'(en_q), 64'(m_en));
        chk({tag, " ovf"}, 64'(ovf_q), 64'(m_ovf));
        chk({tag, " ie"}, 64'(ie_q), 64'(m_ie));
        chk({tag, " irq"}, 64'(irq), 64'(|(m_ovf & m_ie)));
        chk({tag, " ctrl"}, 64'(ctrl_q), 64'({m_long, m_gen}));
    endtask

    task automatic set_type(int idx, logic [9:0] t);
        evtype_we = 1; wr_idx = 5'(idx); evtype_wdata = t; tick();
    endtask

    task automatic wr_cnt(int idx, logic [63:0] v);
        cnt_we = 1; wr_idx = 5'(idx); cnt_wdata = v; tick();
    endtask

    task automatic do_ctrl(logic [3:0] v);
        ctrl_we = 1; ctrl_wdata = v; tick();
    endtask

    task automatic pulse(int e);
        evt_in[e] = 1'b1; tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] v, held;
        int seed;
        clear_inputs(); rd_idx = '0; model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_state("R1");
        chk("R1 irq low", 64'(irq), 64'd0);

        set_type(0, 10'd5); set_type(1, 10'h01E); set_type(2, 10'h000); set_type(3, 10'h01E);
        mask_wdata = 32'h8000_000F; en_set_we = 1; tick();
        do_ctrl(4'b0001);
        // R2 external events
        repeat (3) pulse(5);
        rd(0, v); chk("R2 three pulses", v, 64'd3);
        pulse(6);
        rd(0, v); chk("R2 other event ignored", v, 64'd3);
        check_state("R2");

        // R5 and R7 legacy wrap with chain
        wr_cnt(0, 64'hFFFF_FFFF);
        pulse(5);
        rd(0, v); chk("R5 wrap to zero", v, 64'd0);
        rd(1, v); chk("R7 chained increment", v, 64'd1);
        chk("R5 own ovf bit", 64'(ovf_q[0]), 64'd1);
        chk("R7 odd ovf clear", 64'(ovf_q[1]), 64'd0);
        chk("R11 irq masked", 64'(irq), 64'd0);
        mask_wdata = 32'h1; ie_set_we = 1; tick();
        chk("R11 irq raised", 64'(irq), 64'd1);
        mask_wdata = 32'h1; ovf_clr_we = 1; tick();
        chk("R11 irq dropped", 64'(irq), 64'd0);
        wr_cnt(0, 64'hABCD_0000_1234_5678);
        rd(0, v); chk("R5 write keeps low word", v, 64'h1234_5678);

        // R7 chain lost when odd counter disabled
        mask_wdata = 32'h2; en_clr_we = 1; tick();
        wr_cnt(0, 64'hFFFF_FFFF);
        pulse(5);
        rd(1, v); chk("R7 disabled odd holds", v, 64'd1);
        chk("R7 even still flags", 64'(ovf_q[0]), 64'd1);
        mask_wdata = 32'h2; en_set_we = 1; tick();

        // R8 software increment
        repeat (3) begin mask_wdata = 32'h4; swinc_we = 1; tick(); end
        rd(2, v); chk("R8 three increments", v, 64'd3);
        mask_wdata = 32'h1; swinc_we = 1; tick();
        rd(0, v); chk("R8 non-swinc type ignores", v, 64'd0);
        wr_cnt(2, 64'hFFFF_FFFF);
        mask_wdata = 32'h4; swinc_we = 1; tick();
        rd(2, v); chk("R8 swinc wrap", v, 64'd0);
        rd(3, v); chk("R8 swinc wrap chains", v, 64'd1);
        chk("R8 swinc ovf bit", 64'(ovf_q[2]), 64'd1);
        check_state("R8");

        // R6 long mode
        mask_wdata = 32'hFFFF_FFFF; ovf_clr_we = 1; tick();
        do_ctrl(4'b1001);
        wr_cnt(0, 64'hFFFF_FFFF);
        pulse(5);
        rd(0, v); chk("R6 crosses 32 bits", v, 64'h1_0000_0000);
        chk("R6 no early ovf", 64'(ovf_q[0]), 64'd0);
        wr_cnt(0, 64'hFFFF_FFFF_FFFF_FFFF);
        pulse(5);
        rd(0, v); chk("R6 64-bit wrap", v, 64'd0);
        chk("R6 64-bit ovf", 64'(ovf_q[0]), 64'd1);
        check_state("R6");

        // R4 cycle counter wrap
        wr_cnt(31, 64'hFFFF_FFFF_FFFF_FFFE);
        rd(31, v); chk("R12 cycle write", v, 64'hFFFF_FFFF_FFFF_FFFE);
        tick(); tick();
        rd(31, v); chk("R4 cycle wrap", v, 64'd0);
        chk("R4 cycle ovf bit", 64'(ovf_q[31]), 64'd1);

        // R3 global stop
        do_ctrl(4'b0000);
        rd(31, held);
        pulse(5); tick();
        rd(31, v); chk("R3 cycle holds", v, held);
        rd(0, v); chk("R3 event counter holds", v, 64'd0);

        // R9 clears
        wr_cnt(1, 64'd77);
        do_ctrl(4'b0011);
        rd(1, v); chk("R9 events cleared", v, 64'd0);
        rd(31, v); chk("R9 cycle untouched", v, held);
        do_ctrl(4'b0101);
        rd(31, v); chk("R9 cycle cleared", v, 64'd0);

        // R12 write beats increment; cycle type reads zero
        evt_in[5] = 1'b1; cnt_we = 1; wr_idx = 5'd0; cnt_wdata = 64'd100; tick();
        rd(0, v); chk("R12 write wins", v, 64'd100);
        rd_idx = 5'd31; #1; chk("R12 cycle type zero", 64'(rd_evtype), 64'd0);

        // R10 set wins over clear; invalid bits read zero
        mask_wdata = 32'h0000_0401; ie_set_we = 1; ie_clr_we = 1; tick();
        chk("R10 set wins", 64'(ie_q), 64'(32'h1));
        check_state("R10");

        // constrained random phase
        seed = $urandom(32'd20240607);
        for (int c = 0; c < 3000; c++) begin
            int r;
            logic [9:0] tsel [6];
            tsel[0] = 10'h000; tsel[1] = 10'h01E; tsel[2] = 10'd3;
            tsel[3] = 10'd5;   tsel[4] = 10'd7;   tsel[5] = 10'd40;
            r = int'($urandom % 100);
            if ($urandom % 3 != 0) evt_in[$urandom % EC] = 1'b1;
            if (r < 20) begin swinc_we = 1; mask_wdata = $urandom; end
            else if (r < 30) begin
                cnt_we = 1;
                wr_idx = ($urandom % 2 == 0) ? 5'd31 : 5'($urandom % N);
                cnt_wdata = ($urandom % 2 == 0) ? 64'hFFFF_FFFF_FFFF_FFF0 + 64'($urandom % 16)
                                                : {32'($urandom), 32'hFFFF_FFF0 + 32'($urandom % 16)};
            end
            else if (r < 35) begin evtype_we = 1; wr_idx = 5'($urandom % N); evtype_wdata = tsel[$urandom % 6]; end
            else if (r < 45) begin en_set_we = 1; en_clr_we = ($urandom % 4 == 0); mask_wdata = $urandom; end
            else if (r < 50) begin en_clr_we = 1; mask_wdata = $urandom; end
            else if (r < 56) begin ovf_clr_we = 1; ovf_set_we = ($urandom % 5 == 0); mask_wdata = $urandom; end
            else if (r < 62) begin ie_set_we = 1; ie_clr_we = ($urandom % 2 == 0); mask_wdata = $urandom; end
            else if (r < 65) begin
                ctrl_we = 1;
                ctrl_wdata = {1'($urandom), 1'($urandom % 8 == 0), 1'($urandom % 8 == 0), 1'($urandom % 5 != 0)};
            end
            tick();
            if (c % 8 == 7) check_state("R2 random");
        end
        check_state("R10 random end");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule